// File: doc/BRIEF.md
# Trimmed-Mean Touch Sample Filter

This block cleans up the raw conversion results of one resistive touch channel. Samples of 12 bits arrive as a valid/data stream. The block gathers them into groups of a size set by a 2-bit mode. From each group it throws away an equal number of the highest and the lowest readings. It averages what remains, and the average is formed with a shift because the number of survivors is always two or four. Mode 0 turns the filter off, and every sample then comes straight out one cycle later.

Two spread checks can reject a group. The spread is the distance between the largest and the smallest surviving sample. A relative check compares it with full scale divided by a power of two. An absolute check compares it with a fixed power of two. Either check is disabled by a code of zero. A rejected group gives a one-cycle invalid pulse in place of a result. A synchronous clear throws away a partly collected group.

Top module: `trim_filter`

## Requirements
- R1: Modes 1, 2 and 3 produce exactly one result pulse per 4, 6 and 8 accepted samples respectively. The pulse appears in the cycle after the clock edge that accepts the last sample of the group, and no pulse appears earlier in the group.
- R2: In mode 0 each accepted sample appears on `out_data` with `out_valid` high one cycle after acceptance. The range checks do not apply, and `out_invalid` stays low.
- R3: Mode 1 drops the 1 largest and 1 smallest samples and outputs floor(sum of the 2 kept / 2). Mode 2 drops 1 of each and mode 3 drops 2 of each, and both output floor(sum of the 4 kept / 4).
- R4: For relative code c in 1..7 the limit is 4095 >> (c+2), which runs from 511 down to 7. The group is rejected when the kept maximum minus the kept minimum exceeds the limit. A spread equal to the limit is accepted.
- R5: For absolute code c in 1..7 the limit is 2^(10-c), which runs from 512 down to 8, and the same greater-than test applies.
- R6: Code 0 disables its check. When both checks are enabled, failing either one rejects the group.
- R7: A rejected group raises `out_invalid` for one cycle with `out_valid` low, and `out_data` keeps its previous value.
- R8: `clr` high discards any partial group and ignores a sample offered in the same cycle. No result or invalid pulse follows in the next cycle, and the next group starts from zero samples.
- R9: After reset `out_valid`, `out_invalid` and `out_data` are all 0.
- R10: `out_valid` and `out_invalid` are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of group collection |
| mode | input | 2 | 0 bypass, 1 keep 2 of 4, 2 keep 4 of 6, 3 keep 4 of 8 |
| rel_code | input | 3 | Relative spread limit code, 0 disables |
| abs_code | input | 3 | Absolute spread limit code, 0 disables |
| in_valid | input | 1 | Sample present |
| in_data | input | 12 | Unsigned sample |
| out_valid | output | 1 | Filtered result pulse |
| out_invalid | output | 1 | Rejected group pulse |
| out_data | output | 12 | Last filtered result |

## Verification
The properties assume that `mode` changes only when no group is partly collected, which means right after a finished group or together with a `clr`. The group-count check and the pass-through check depend on that assumption. The stimulus sets the mode and the range codes only between complete groups, and every partial group it builds is ended by a `clr`. The range codes are assumed steady while the last sample of a group is taken, and the tasks hold them constant for the whole group.

// File: rtl/trim_filter_pkg.sv
package trim_filter_pkg;

    typedef enum logic [1:0] {
        FM_PASS = 2'd0,
        FM_2OF4 = 2'd1,
        FM_4OF6 = 2'd2,
        FM_4OF8 = 2'd3
    } fmode_e;

    // samples gathered before one result
    function automatic int unsigned grp_size(fmode_e m);
        case (m)
            FM_2OF4: return 4;
            FM_4OF6: return 6;
            FM_4OF8: return 8;
            default: return 1;
        endcase
    endfunction

    // samples thrown away at each end of the sorted group
    function automatic int unsigned drop_cnt(fmode_e m);
        return (m == FM_4OF8) ? 2 : 1;
    endfunction

    // log2 of the number of survivors
    function automatic int unsigned keep_shift(fmode_e m);
        return (m == FM_2OF4) ? 1 : 2;
    endfunction

endpackage

// File: rtl/trim_rank_keep.sv
// Keeps the RANK most extreme values seen so far, ordered from the most
// extreme down; purely combinational insertion of one new value.
module trim_rank_keep #(
    parameter int DW        = 12,
    parameter int RANK      = 3,
    parameter bit KEEP_HIGH = 1'b1
) (
    input  logic [RANK-1:0][DW-1:0] cur,
    input  logic [DW-1:0]           x,
    output logic [RANK-1:0][DW-1:0] nxt
);

    function automatic logic beats(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return KEEP_HIGH ? (a > b) : (a < b);
    endfunction

    for (genvar i = 0; i < RANK; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign nxt[i] = beats(x, cur[i]) ? x : cur[i];
        end else begin : g_tail
            assign nxt[i] = beats(x, cur[i-1]) ? cur[i-1]
                          : (beats(x, cur[i]) ? x : cur[i]);
        end
    end

endmodule

// File: rtl/trim_range_limit.sv
// Compares the spread of the kept samples against both programmable limits.
module trim_range_limit #(
    parameter int DW       = 12,
    parameter int REL_BIAS = 2,
    parameter int ABS_EXP  = 10
) (
    input  logic [2:0]    rel_code,
    input  logic [2:0]    abs_code,
    input  logic [DW-1:0] spread,
    output logic          too_wide
);

    localparam logic [DW-1:0] FULL = '1;

    logic [DW-1:0] rel_lim;
    logic [DW:0]   abs_lim;

    always_comb begin
        rel_lim  = FULL >> (int'(rel_code) + REL_BIAS);
        abs_lim  = (DW+1)'(1) << (ABS_EXP - int'(abs_code));
        too_wide = ((rel_code != 3'd0) && (spread > rel_lim)) ||
                   ((abs_code != 3'd0) && ({1'b0, spread} > abs_lim));
    end

endmodule

// File: rtl/trim_filter.sv
module trim_filter
    import trim_filter_pkg::*;
#(
    parameter int DW       = 12,
    parameter int MAXDROP  = 2,
    parameter int MAXGRP   = 8,
    parameter int REL_BIAS = 2,
    parameter int ABS_EXP  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    mode,
    input  logic [2:0]    rel_code,
    input  logic [2:0]    abs_code,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_invalid,
    output logic [DW-1:0] out_data
);

    localparam int RANK = MAXDROP + 1;
    localparam int CW   = $clog2(MAXGRP + 1);
    localparam int SW   = DW + $clog2(MAXGRP);

    typedef logic [RANK-1:0][DW-1:0] rank_t;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] sum;
        rank_t         hi;
        rank_t         lo;
        logic          ov;
        logic          oi;
        logic [DW-1:0] od;
    } st_t;

    st_t    st_d, st_q;
    fmode_e md;
    rank_t  hi_n, lo_n;

    logic [SW-1:0] sum_n;
    logic [SW-1:0] kept;
    logic [SW-1:0] mean;
    logic [DW-1:0] spread;
    logic          too_wide;
    int unsigned   drop;

    assign md = fmode_e'(mode);

    trim_rank_keep #(.DW(DW), .RANK(RANK), .KEEP_HIGH(1'b1)) u_top_rank (
        .cur (st_q.hi),
        .x   (in_data),
        .nxt (hi_n)
    );

    trim_rank_keep #(.DW(DW), .RANK(RANK), .KEEP_HIGH(1'b0)) u_bot_rank (
        .cur (st_q.lo),
        .x   (in_data),
        .nxt (lo_n)
    );

    trim_range_limit #(.DW(DW), .REL_BIAS(REL_BIAS), .ABS_EXP(ABS_EXP)) u_limit (
        .rel_code (rel_code),
        .abs_code (abs_code),
        .spread   (spread),
        .too_wide (too_wide)
    );

    // arithmetic on the group including the sample now offered
    always_comb begin
        drop  = drop_cnt(md);
        sum_n = st_q.sum + SW'(in_data);
        kept  = sum_n - SW'(hi_n[0]) - SW'(lo_n[0]);
        if (drop == 2) begin
            kept = kept - SW'(hi_n[1]) - SW'(lo_n[1]);
        end
        spread = hi_n[drop] - lo_n[drop];
        mean   = kept >> keep_shift(md);
    end

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.oi = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
            st_d.sum = '0;
            st_d.hi  = '0;
            st_d.lo  = '1;
        end else if (in_valid) begin
            if (md == FM_PASS) begin
                st_d.ov = 1'b1;
                st_d.od = in_data;
            end else if (st_q.cnt >= CW'(grp_size(md) - 1)) begin
                if (too_wide) begin
                    st_d.oi = 1'b1;
                end else begin
                    st_d.ov = 1'b1;
                    st_d.od = DW'(mean);
                end
                st_d.cnt = '0;
                st_d.sum = '0;
                st_d.hi  = '0;
                st_d.lo  = '1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
                st_d.sum = sum_n;
                st_d.hi  = hi_n;
                st_d.lo  = lo_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lo  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.ov;
    assign out_invalid = st_q.oi;
    assign out_data    = st_q.od;

endmodule

// File: rtl/trim_filter_chk.sv
module trim_filter_chk
    import trim_filter_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic [1:0]  mode,
    input logic        in_valid,
    input logic [11:0] in_data,
    input logic        out_valid,
    input logic        out_invalid,
    input logic [11:0] out_data
);

    logic [3:0] seen;
    logic [3:0] grp;

    assign grp = 4'(grp_size(fmode_e'(mode)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (clr) begin
            seen <= '0;
        end else if (in_valid && mode != 2'd0) begin
            seen <= (seen + 4'd1 >= grp) ? 4'd0 : seen + 4'd1;
        end
    end

    // R10: one kind of pulse at a time
    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_invalid));

    // R2: bypass delivers the sample a cycle later
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && in_valid && !clr) |=> (out_valid && out_data == $past(in_data)));

    // R8: nothing follows a cleared or empty cycle
    a_r8_quiet_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !in_valid) |=> (!out_valid && !out_invalid));

    // R7: rejected group leaves the data untouched
    a_r7_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> $stable(out_data));

    // R1: no result before the group is full
    a_r1_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && in_valid && !clr && (seen + 4'd1 < grp)) |=> (!out_valid && !out_invalid));

endmodule

bind trim_filter trim_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .mode        (mode),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_invalid (out_invalid),
    .out_data    (out_data)
);

// File: tb/trim_filter_tb.sv
module trim_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  rel_code = 3'd0;
    logic [2:0]  abs_code = 3'd0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        out_valid;
    logic        out_invalid;
    logic [11:0] out_data;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    trim_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .mode        (mode),
        .rel_code    (rel_code),
        .abs_code    (abs_code),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_invalid (out_invalid),
        .out_data    (out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // feeds one full group and checks idle pulses inside it and the result after it
    task automatic do_group(input logic [1:0] md, input logic [2:0] rc,
                            input logic [2:0] ac, input logic [11:0] s [8],
                            input string req);
        int m, k, sh, sum, spread, expv, prev;
        bit wide;
        int t [8];
        m  = (md == 2'd1) ? 4 : (md == 2'd2) ? 6 : 8;
        k  = (md == 2'd3) ? 2 : 1;
        sh = (md == 2'd1) ? 1 : 2;
        for (int i = 0; i < 8; i++) t[i] = int'(s[i]);
        for (int i = 0; i < m; i++)
            for (int j = 0; j + 1 < m - i; j++)
                if (t[j] > t[j+1]) begin
                    int tmp = t[j]; t[j] = t[j+1]; t[j+1] = tmp;
                end
        sum = 0;
        for (int i = k; i < m - k; i++) sum += t[i];
        expv   = sum >> sh;
        spread = t[m-1-k] - t[k];
        wide   = (rc != 0 && spread > (4095 >> (rc + 2))) ||
                 (ac != 0 && spread > (1 << (10 - ac)));
        @(negedge clk);
        mode = md; rel_code = rc; abs_code = ac;
        prev = int'(out_data);
        for (int i = 0; i < m; i++) begin
            if (i > 0) check({req, " R1 idle inside group"}, int'(out_valid | out_invalid), 0);
            in_valid = 1'b1;
            in_data  = s[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        check({req, " R10 pulse kind"}, int'(out_valid & out_invalid), 0);
        if (wide) begin
            check({req, " R7 invalid pulse"}, int'(out_invalid), 1);
            check({req, " R7 valid low"}, int'(out_valid), 0);
            check({req, " R7 data held"}, int'(out_data), prev);
        end else begin
            check({req, " R1 valid pulse"}, int'(out_valid), 1);
            check({req, " R3 mean"}, int'(out_data), expv);
        end
        @(negedge clk);
        check({req, " R10 single cycle"}, int'(out_valid | out_invalid), 0);
    endtask

    task automatic t_reset();
        check("R9 reset valid", int'(out_valid), 0);
        check("R9 reset invalid", int'(out_invalid), 0);
        check("R9 reset data", int'(out_data), 0);
    endtask

    task automatic t_pass();
        logic [11:0] v [3] = '{12'd17, 12'd4095, 12'd0};
        @(negedge clk);
        mode = 2'd0; rel_code = 3'd1; abs_code = 3'd7;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_data  = v[i];
            @(negedge clk);
            check("R2 pass valid", int'(out_valid), 1);
            check("R2 pass invalid low", int'(out_invalid), 0);
            check("R2 pass data", int'(out_data), int'(v[i]));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 pass idle", int'(out_valid), 0);
    endtask

    task automatic t_modes();
        do_group(2'd1, 3'd0, 3'd0, '{100, 900, 300, 500, 0, 0, 0, 0}, "R3 mode1");
        do_group(2'd2, 3'd0, 3'd0, '{10, 2000, 40, 4095, 30, 20, 0, 0}, "R3 mode2");
        do_group(2'd3, 3'd0, 3'd0, '{0, 4095, 1000, 1001, 1002, 1003, 4095, 0}, "R3 mode3");
        do_group(2'd3, 3'd0, 3'd0, '{7, 7, 7, 7, 7, 7, 7, 7}, "R1 mode3 flat");
    endtask

    task automatic t_relative();
        do_group(2'd1, 3'd1, 3'd0, '{0, 1000, 400, 1000, 0, 0, 0, 0}, "R4 rel over");
        do_group(2'd1, 3'd1, 3'd0, '{1000, 489, 0, 2000, 0, 0, 0, 0}, "R4 rel equal");
        do_group(2'd1, 3'd7, 3'd0, '{50, 57, 0, 4000, 0, 0, 0, 0}, "R4 rel7 equal");
        do_group(2'd1, 3'd7, 3'd0, '{50, 58, 0, 4000, 0, 0, 0, 0}, "R4 rel7 over");
    endtask

    task automatic t_absolute();
        do_group(2'd1, 3'd0, 3'd3, '{200, 328, 0, 4095, 0, 0, 0, 0}, "R5 abs equal");
        do_group(2'd1, 3'd0, 3'd3, '{200, 329, 0, 4095, 0, 0, 0, 0}, "R5 abs over");
        do_group(2'd1, 3'd0, 3'd1, '{100, 613, 0, 4095, 0, 0, 0, 0}, "R5 abs1 over");
        do_group(2'd3, 3'd0, 3'd2, '{0, 0, 900, 1156, 1000, 1000, 4095, 4095}, "R5 abs2 equal m8");
        do_group(2'd2, 3'd0, 3'd2, '{0, 900, 1157, 1000, 1000, 4095, 0, 0}, "R5 abs2 over m6");
    endtask

    task automatic t_combined();
        do_group(2'd1, 3'd0, 3'd0, '{0, 100, 4000, 4095, 0, 0, 0, 0}, "R6 disabled");
        do_group(2'd1, 3'd1, 3'd1, '{100, 612, 0, 4095, 0, 0, 0, 0}, "R6 rel fails abs ok");
        do_group(2'd1, 3'd7, 3'd1, '{100, 105, 0, 4095, 0, 0, 0, 0}, "R6 both pass");
    endtask

    task automatic t_clear();
        @(negedge clk);
        mode = 2'd1; rel_code = 3'd0; abs_code = 3'd0;
        in_valid = 1'b1; in_data = 12'd4000;
        @(negedge clk);
        in_data = 12'd3000;
        @(negedge clk);
        clr = 1'b1; in_data = 12'd3500;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        check("R8 quiet after clear", int'(out_valid | out_invalid), 0);
        do_group(2'd1, 3'd0, 3'd0, '{10, 20, 30, 40, 0, 0, 0, 0}, "R8 fresh group");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_pass();
        t_relative();
        t_absolute();
        t_combined();
        t_clear();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule